// File: doc/BRIEF.md
# Prescaled 64-bit System Timer with Snapshot Read and Compare Channels

This block keeps a 64-bit up-counter that advances at a programmable rate taken from the system clock. The rate comes from a divider value D. The counter steps once every 2×(D+1) clocks. Software gets a consistent 64-bit reading by issuing a snapshot command, which copies the whole counter into two 32-bit holding words in one cycle. It then reads those words at leisure. Software can also preload either half of the counter, for example to restore time after a power transition.

Six compare channels each hold a 32-bit value. A channel fires on the tick at which the low counter word steps onto its value. When a channel fires, it sets its own sticky status bit. Software clears a status bit by writing 1 to it. A per-channel enable routes status onto a single level interrupt. Channel 0 is intended for one-shot event scheduling. Channel 5 has an extra watchdog-enable bit that is only stored and has no other effect.

Access is through a plain 32-bit port with a word address. A write completes in one clock. A read is combinational from the addressed register.

Top module: `tick_timer64`

## Requirements
- R1: While reset is asserted, every readable word (word addresses 0 to 15) reads 0 and `irq` is low.
- R2: The counter steps exactly every 2×(D+1) clocks, where D is the divider (word 11, low 16 bits). A write to word 0, word 1 or word 11 restarts the divider phase, so the first step after such a write happens 2×(D+1) clocks later.
- R3: The counter is 64 bits wide. A step from low word 0xFFFFFFFF carries into the high word.
- R4: A write to word 0 loads the low 32 counter bits and a write to word 1 loads the high 32 bits. Each write leaves the other half unchanged, and the loaded value is readable live from the same word.
- R5: Writing a value with bit 0 set to word 12 copies the counter value held before that clock edge into word 13 (low) and word 14 (high). Writing with bit 0 clear leaves words 13 and 14 unchanged.
- R6: Status bit n (word 8) sets on the clock edge at which a counter step makes the low word equal to compare word n (words 2 to 7 for n = 0 to 5). Loading the counter directly to that value does not set the bit.
- R7: Writing 1 to status bit n clears it, and writing 0 leaves it unchanged.
- R8: If a compare event on channel n and a write-1 clear of bit n fall on the same edge, the bit stays set.
- R9: `irq` is high exactly when some status bit n and interrupt-enable bit n (word 9, bit n) are both 1, and it stays high until the bit is cleared or disabled.
- R10: Word 10 bit 0 stores the watchdog enable for channel 5. It reads back and has no effect on `irq`.
- R11: Compare words and the divider read back what was written. Word 12 and word 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted divider phase shows up in the very next snapshot as a count that is off by one or more steps. Each snapshot is compared against an exact step count derived from the divider and the number of clocks since the last restart. A compare that fires on the wrong step shows within one clock, because status is sampled on the edge just before and the edge just at the expected match. Lost carries or mis-steered half loads show in the first snapshot after the load. Clear-versus-set ordering mistakes show in the status word immediately after the colliding edge, since the bench times its clear exactly onto the match edge.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int unsigned WORD_W = 32;

  // Value the low counter word takes after one step.
  function automatic logic [31:0] next_low(input logic [63:0] cnt);
    logic [31:0] lo;
    lo = cnt[31:0];
    return lo + 32'd1;
  endfunction

  // Last prescaler phase for a divider value: period is 2*(d+1).
  function automatic logic [32:0] presc_last(input logic [31:0] d);
    return {d, 1'b1};
  endfunction

  // One decoded write target per control register.
  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic status;
    logic inten;
    logic wden;
    logic divider;
    logic snap_cmd;
  } wr_sel_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  import timer_pkg::*;

  localparam int unsigned PC_W = DIV_W + 1;

  logic [PC_W-1:0] phase_q;
  logic [32:0]     last_full;
  logic [PC_W-1:0] last_phase;
  logic            at_last;

  assign last_full  = presc_last(32'(div_i));
  assign last_phase = last_full[PC_W-1:0];
  assign at_last    = (phase_q == last_phase);
  assign tick_o     = at_last && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i || at_last) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tt_counter64.sv
module tt_counter64 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        lo_we_i,
  input  logic        hi_we_i,
  input  logic [31:0] wdata_i,
  input  logic        snap_i,
  output logic [63:0] cnt_o,
  output logic [63:0] snap_o
);

  logic [63:0] cnt_q;
  logic [63:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (lo_we_i || hi_we_i) begin
      if (lo_we_i) cnt_q[31:0]  <= wdata_i;
      if (hi_we_i) cnt_q[63:32] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_i) begin
      snap_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;

endmodule

// File: rtl/tt_match_bank.sv
module tt_match_bank #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [31:0]          next_lo_i,
  input  logic [NUM_CH-1:0]    we_i,
  input  logic [31:0]          wdata_i,
  output logic [NUM_CH*32-1:0] cmp_o,
  output logic [NUM_CH-1:0]    hit_o
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [31:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (we_i[ch]) begin
        cmp_q <= wdata_i;
      end
    end

    assign cmp_o[ch*32 +: 32] = cmp_q;
    assign hit_o[ch]          = tick_i && (next_lo_i == cmp_q);
  end

endmodule

// File: rtl/tt_status.sv
module tt_status #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic              en_we_i,
  input  logic [NUM_CH-1:0] en_wdata_i,
  output logic [NUM_CH-1:0] status_o,
  output logic [NUM_CH-1:0] inten_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] status_q;
  logic [NUM_CH-1:0] inten_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inten_q <= '0;
    end else if (en_we_i) begin
      inten_q <= en_wdata_i;
    end
  end

  assign status_o = status_q;
  assign inten_o  = inten_q;
  assign irq_o    = |(status_q & inten_q);

endmodule

// File: rtl/tick_timer64.sv
module tick_timer64 #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import timer_pkg::*;

  localparam int unsigned IX_CNT_LO  = 0;
  localparam int unsigned IX_CNT_HI  = 1;
  localparam int unsigned IX_CMP0    = 2;
  localparam int unsigned IX_STATUS  = IX_CMP0 + NUM_CH;
  localparam int unsigned IX_INTEN   = IX_STATUS + 1;
  localparam int unsigned IX_WDEN    = IX_INTEN + 1;
  localparam int unsigned IX_DIV     = IX_WDEN + 1;
  localparam int unsigned IX_SNAPCMD = IX_DIV + 1;
  localparam int unsigned IX_SNAP_LO = IX_SNAPCMD + 1;
  localparam int unsigned IX_SNAP_HI = IX_SNAP_LO + 1;

  // Decoded write strobes
  wr_sel_t           wsel;
  logic [NUM_CH-1:0] cmp_we;

  always_comb begin
    wsel.cnt_lo   = bus_we && (bus_addr == ADDR_W'(IX_CNT_LO));
    wsel.cnt_hi   = bus_we && (bus_addr == ADDR_W'(IX_CNT_HI));
    wsel.status   = bus_we && (bus_addr == ADDR_W'(IX_STATUS));
    wsel.inten    = bus_we && (bus_addr == ADDR_W'(IX_INTEN));
    wsel.wden     = bus_we && (bus_addr == ADDR_W'(IX_WDEN));
    wsel.divider  = bus_we && (bus_addr == ADDR_W'(IX_DIV));
    wsel.snap_cmd = bus_we && (bus_addr == ADDR_W'(IX_SNAPCMD));
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp_we
    assign cmp_we[ch] = bus_we && (bus_addr == ADDR_W'(IX_CMP0 + ch));
  end

  // Named internal events
  logic              cnt_we;
  logic              snap_go;
  logic              tick;
  logic [63:0]       cnt;
  logic [63:0]       snap;
  logic [31:0]       next_lo;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] stat_clr;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] inten;
  logic              inten_we;
  logic [DIV_W-1:0]  div_q;
  logic              wden_q;

  assign cnt_we   = wsel.cnt_lo || wsel.cnt_hi;
  assign snap_go  = wsel.snap_cmd && bus_wdata[0];
  assign next_lo  = next_low(cnt);
  assign stat_clr = wsel.status ? bus_wdata[NUM_CH-1:0] : '0;
  assign inten_we = wsel.inten;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      wden_q <= 1'b0;
    end else begin
      if (wsel.divider) div_q  <= bus_wdata[DIV_W-1:0];
      if (wsel.wden)    wden_q <= bus_wdata[0];
    end
  end

  tt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_i     (div_q),
    .restart_i (cnt_we || wsel.divider),
    .tick_o    (tick)
  );

  tt_counter64 u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .lo_we_i (wsel.cnt_lo),
    .hi_we_i (wsel.cnt_hi),
    .wdata_i (bus_wdata),
    .snap_i  (snap_go),
    .cnt_o   (cnt),
    .snap_o  (snap)
  );

  logic [NUM_CH*32-1:0] cmp_flat;

  tt_match_bank #(.NUM_CH(NUM_CH)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .next_lo_i (next_lo),
    .we_i      (cmp_we),
    .wdata_i   (bus_wdata),
    .cmp_o     (cmp_flat),
    .hit_o     (hit)
  );

  tt_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .clr_i      (stat_clr),
    .en_we_i    (inten_we),
    .en_wdata_i (bus_wdata[NUM_CH-1:0]),
    .status_o   (status),
    .inten_o    (inten),
    .irq_o      (irq)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(IX_CNT_LO))  bus_rdata = cnt[31:0];
    if (bus_addr == ADDR_W'(IX_CNT_HI))  bus_rdata = cnt[63:32];
    if (bus_addr == ADDR_W'(IX_STATUS))  bus_rdata = 32'(status);
    if (bus_addr == ADDR_W'(IX_INTEN))   bus_rdata = 32'(inten);
    if (bus_addr == ADDR_W'(IX_WDEN))    bus_rdata = 32'(wden_q);
    if (bus_addr == ADDR_W'(IX_DIV))     bus_rdata = 32'(div_q);
    if (bus_addr == ADDR_W'(IX_SNAP_LO)) bus_rdata = snap[31:0];
    if (bus_addr == ADDR_W'(IX_SNAP_HI)) bus_rdata = snap[63:32];
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (bus_addr == ADDR_W'(IX_CMP0 + ch)) bus_rdata = cmp_flat[ch*32 +: 32];
    end
  end

endmodule

// File: rtl/tick_timer64_chk.sv
module tick_timer64_chk #(
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_we,
  input logic              snap_go,
  input logic              inten_we,
  input logic [63:0]       cnt,
  input logic [63:0]       snap,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] stat_clr,
  input logic [NUM_CH-1:0] status,
  input logic              irq
);

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we) |=> (cnt == $past(cnt) + 64'd1));

  assert_snap_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_go |=> (snap == $past(cnt)));

  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(snap));

  assert_hit_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> tick);

  assert_clear_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~$past(stat_clr)) == '0));

  assert_hit_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|hit) || $past(inten_we)));

endmodule

bind tick_timer64 tick_timer64_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_we   (cnt_we),
  .snap_go  (snap_go),
  .inten_we (inten_we),
  .cnt      (cnt),
  .snap     (snap),
  .hit      (hit),
  .stat_clr (stat_clr),
  .status   (status),
  .irq      (irq)
);

// File: tb/tb_tick_timer64.sv
`timescale 1ns/10ps
module tb_tick_timer64;

  localparam int A_CNT_LO = 0;
  localparam int A_CNT_HI = 1;
  localparam int A_CMP0   = 2;
  localparam int A_STATUS = 8;
  localparam int A_INTEN  = 9;
  localparam int A_WDEN   = 10;
  localparam int A_DIV    = 11;
  localparam int A_SNAP   = 12;
  localparam int A_SLO    = 13;
  localparam int A_SHI    = 14;
  localparam int A_FREE   = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  tick_timer64 dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [63:0] exp_count(input logic [63:0] start, input int idle, input int d);
    return start + 64'(idle / (2 * (d + 1)));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; consumes exactly one rising edge.
  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = 4'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  // Consumes no clock edge.
  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    #0.05;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_snap(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_SLO, lo);
    rd(A_SHI, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r, prev_lo;
    logic [63:0] v, s;
    int seed;
    seed = $urandom(32'h5A17);

    // R1: reset state while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      rd(a, r);
      chk("R1 reset word", 64'(r), 64'd0);
    end
    chk("R1 irq in reset", 64'(irq), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: readback and zero words
    for (int ch = 0; ch < 6; ch++) begin
      logic [31:0] w;
      w = $urandom;
      wr(A_CMP0 + ch, w);
      rd(A_CMP0 + ch, r);
      chk("R11 compare readback", 64'(r), 64'(w));
    end
    wr(A_DIV, 32'h0001_0007);
    rd(A_DIV, r);
    chk("R11 divider readback (16 bits)", 64'(r), 64'h7);
    rd(A_SNAP, r);
    chk("R11 snapshot command reads 0", 64'(r), 64'd0);
    rd(A_FREE, r);
    chk("R11 unused word reads 0", 64'(r), 64'd0);

    // R4: half loads, live readback and snapshot
    begin
      logic [31:0] h, l;
      h = $urandom; l = $urandom;
      wr(A_DIV, 32'd3);
      wr(A_CNT_HI, h);
      wr(A_CNT_LO, l);
      rd(A_CNT_LO, r);
      chk("R4 live low", 64'(r), 64'(l));
      rd(A_CNT_HI, r);
      chk("R4 live high", 64'(r), 64'(h));
      wr(A_SNAP, 32'd1);
      read_snap(v);
      chk("R4 snapshot after load", v, {h, l});
      wr(A_CNT_LO, 32'h1234_5678);
      rd(A_CNT_HI, r);
      chk("R4 high untouched by low write", 64'(r), 64'(h));
    end

    // R2: random divider and idle lengths
    for (int it = 0; it < 24; it++) begin
      int d, n;
      logic [63:0] st;
      d  = int'($urandom_range(0, 5));
      n  = int'($urandom_range(0, 40));
      st = {32'($urandom), 32'($urandom)};
      if (it == 0) begin d = 0; n = 1; end
      if (it == 1) begin d = 2; n = 5; end
      if (it == 2) begin d = 2; n = 6; end
      wr(A_DIV, 32'(d));
      wr(A_CNT_HI, st[63:32]);
      wr(A_CNT_LO, st[31:0]);
      idle(n);
      wr(A_SNAP, 32'd1);
      read_snap(v);
      chk("R2 step count", v, exp_count(st, n, d));
    end

    // R3: carry into the high word
    wr(A_DIV, 32'd0);
    wr(A_CNT_HI, 32'hABCD_0001);
    wr(A_CNT_LO, 32'hFFFF_FFFF);
    idle(2);
    wr(A_SNAP, 32'd1);
    read_snap(v);
    chk("R3 carry", v, 64'hABCD_0002_0000_0000);

    // R5: command with bit 0 clear keeps the snapshot
    read_snap(s);
    idle(7);
    wr(A_SNAP, 32'hFFFF_FFFE);
    read_snap(v);
    chk("R5 snapshot held on bit0=0", v, s);
    wr(A_SNAP, 32'd1);
    read_snap(v);
    chk("R5 snapshot updates on bit0=1", 64'(v != s), 64'd1);

    // R6..R9: compare channels
    for (int it = 0; it < 4; it++) begin
      int c;
      logic [31:0] m;
      c = (it == 0) ? 0 : int'($urandom_range(0, 5));
      m = (it == 1) ? 32'h0000_0001 : $urandom;
      wr(A_DIV, 32'd0);
      wr(A_INTEN, 32'd0);
      for (int ch = 0; ch < 6; ch++) wr(A_CMP0 + ch, m + 32'h0001_0000 + 32'(ch));
      wr(A_CMP0 + c, m);
      wr(A_STATUS, 32'h3F);
      wr(A_CNT_HI, 32'd0);
      wr(A_CNT_LO, m - 32'd3);
      idle(5);
      rd(A_STATUS, r);
      chk("R6 no event one edge early", 64'(r[c]), 64'd0);
      idle(1);
      rd(A_STATUS, r);
      chk("R6 event on matching step", 64'(r), 64'(32'd1 << c));
      chk("R9 irq low while disabled", 64'(irq), 64'd0);
      wr(A_INTEN, 32'd1 << c);
      chk("R9 irq high when enabled", 64'(irq), 64'd1);
      idle(3);
      chk("R9 irq held", 64'(irq), 64'd1);
      wr(A_STATUS, 32'd0);
      rd(A_STATUS, r);
      chk("R7 write 0 keeps status", 64'(r[c]), 64'd1);
      wr(A_STATUS, 32'd1 << c);
      rd(A_STATUS, r);
      chk("R7 write 1 clears status", 64'(r[c]), 64'd0);
      chk("R9 irq low after clear", 64'(irq), 64'd0);
      // R8: clear lands exactly on the matching edge
      wr(A_CNT_LO, m - 32'd3);
      idle(5);
      wr(A_STATUS, 32'd1 << c);
      rd(A_STATUS, r);
      chk("R8 event beats clear", 64'(r[c]), 64'd1);
      wr(A_STATUS, 32'h3F);
      // R6: direct load to the compare value sets nothing
      wr(A_CNT_LO, m);
      rd(A_STATUS, r);
      chk("R6 load does not fire", 64'(r[c]), 64'd0);
    end

    // R10: watchdog enable is storage only
    wr(A_INTEN, 32'd0);
    wr(A_STATUS, 32'h3F);
    wr(A_WDEN, 32'd1);
    rd(A_WDEN, r);
    chk("R10 watchdog enable readback", 64'(r), 64'd1);
    chk("R10 irq unaffected", 64'(irq), 64'd0);
    wr(A_CMP0 + 5, 32'h0000_0010);
    wr(A_CNT_LO, 32'h0000_000F);
    idle(2);
    chk("R10 channel 5 event without enable keeps irq low", 64'(irq), 64'd0);
    rd(A_STATUS, r);
    chk("R10 channel 5 status still sets", 64'(r[5]), 64'd1);
    prev_lo = r;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule